// File: doc/BRIEF.md
# Clock Synthesizer Control Register Bank

This block holds the control word of a clock synthesizer, together with three configuration registers for its dividers, behind a simple write/read port. The control word selects the loop filter bandwidth, the reference source, on-demand operation, a global write lock and the enable. The block also produces the oscillator run signal. That signal depends on the enable, the on-demand bit and a vector of peripheral clock requests.

Two protection layers guard the configuration. The first is the enable bit. While it is stored as 1, the bandwidth, reference and on-demand fields keep their values. The second is the lock bit. Once the lock is set, writes to the control word and to the divider registers are discarded, apart from one output-enable bit in the post-divider register. The lock protects itself, so it clears only on reset. Reserved bandwidth or reference codes are refused field by field, and each refusal is flagged with a single-cycle error pulse.

Top module: `clkgen_ctrl_regs`

## Requirements
- R1: After reset, all four registers read 0, `osc_run` is 0 and `cfg_err` is 0.
- R2: The control word sits at byte address 0x40 with this layout: bandwidth select in bits 13:11, reference select in bits 10:8, on-demand in bit 7, lock in bit 2 and enable in bit 1. Every other bit reads as 0 whatever was written to it.
- R3: While the stored enable bit is 1 before a write, that write leaves the bandwidth, reference and on-demand fields unchanged and raises no error.
- R4: A write to the control word that is neither locked nor frozen and carries a reserved bandwidth code (000, 101, 110 or 111) leaves the bandwidth field unchanged. `cfg_err` is then 1 for exactly the cycle after that write. Codes 001 to 100 are stored.
- R5: A write to the control word that is neither locked nor frozen and carries a reserved reference code (3 to 7) leaves the reference field unchanged and also pulses `cfg_err`. Codes 0 to 2 are stored.
- R6: While the lock bit is 1, writes to the control word (0x40), the feedback divider (0x44) and the reference divider (0x48) change nothing and raise no error. The lock bit stays 1 until reset.
- R7: Bit 0 of the post-divider register (0x4C) stays writable while locked. Its bits 31:1 are protected. Without the lock, all three divider registers take all 32 bits of a write.
- R8: With on-demand 0, `osc_run` equals the enable bit.
- R9: With on-demand 1, `osc_run` is 1 only while enable is 1 and at least one of the 8 `periph_req` lines is 1.
- R10: Without the lock, the enable and lock bits take every control-word write, including writes while enabled. Software can therefore disable the block and then change the frozen fields.
- R11: Reads of addresses other than the four mapped words return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| periph_req | input | 8 | Peripheral clock request lines |
| osc_run | output | 1 | Oscillator run control |
| cfg_err | output | 1 | One-cycle pulse after a refused reserved code |
| bw_sel | output | 3 | Stored loop bandwidth code |
| ref_sel | output | 3 | Stored reference source code |

## Verification
A stuck or wrongly updated field shows up in the read value of its word on the very next read after the write that should have changed it, or should have left it alone. A faulty freeze or lock condition therefore shows as a readback mismatch one cycle after the offending write. Errors in the error path show as a missing or extra `cfg_err` pulse in the cycle right after the write. A fault in the run gating reaches `osc_run` combinationally, in the same cycle as the request or field change that exposes it.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  localparam int unsigned CTRL_OFS  = 32'h40;
  localparam int unsigned WORD_STEP = 4;

  localparam int unsigned BW_LO   = 11;
  localparam int unsigned SRC_LO  = 8;
  localparam int unsigned OD_BIT  = 7;
  localparam int unsigned LK_BIT  = 2;
  localparam int unsigned EN_BIT  = 1;

  typedef struct packed {
    logic [2:0] bw;
    logic [2:0] src;
    logic       od;
    logic       lock;
    logic       en;
  } ctrl_t;

  // bandwidth codes 1..4 name real frequency bands
  function automatic logic bw_code_ok(input logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd4);
  endfunction

  // reference codes 0..2 name real sources
  function automatic logic src_code_ok(input logic [2:0] c);
    return c <= 3'd2;
  endfunction

  function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
    ctrl_t c;
    c.bw   = w[BW_LO +: 3];
    c.src  = w[SRC_LO +: 3];
    c.od   = w[OD_BIT];
    c.lock = w[LK_BIT];
    c.en   = w[EN_BIT];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_pack(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[BW_LO +: 3]  = c.bw;
    w[SRC_LO +: 3] = c.src;
    w[OD_BIT]      = c.od;
    w[LK_BIT]      = c.lock;
    w[EN_BIT]      = c.en;
    return w;
  endfunction

endpackage

// File: rtl/clkgen_ctrl_field.sv
module clkgen_ctrl_field
  import clkgen_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_hit,
  input  ctrl_t wr_val,
  output ctrl_t state,
  output logic  frozen,
  output logic  locked,
  output logic  wr_taken,
  output logic  bw_drop,
  output logic  src_drop,
  output logic  cfg_err
);

  logic cfg_open;

  always_comb begin
    frozen   = state.en;
    locked   = state.lock;
    wr_taken = wr_hit && !locked;
    cfg_open = wr_taken && !frozen;
    bw_drop  = cfg_open && !bw_code_ok(wr_val.bw);
    src_drop = cfg_open && !src_code_ok(wr_val.src);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= '0;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= bw_drop || src_drop;
      if (wr_taken) begin
        state.en   <= wr_val.en;
        state.lock <= wr_val.lock;
      end
      if (cfg_open) begin
        state.od <= wr_val.od;
        if (!bw_drop)  state.bw  <= wr_val.bw;
        if (!src_drop) state.src <= wr_val.src;
      end
    end
  end

endmodule

// File: rtl/clkgen_div_bank.sv
module clkgen_div_bank #(
  parameter int unsigned NREG   = 3,
  parameter int unsigned DATA_W = 32,
  parameter logic [NREG*DATA_W-1:0] EXEMPT = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NREG-1:0]        wr_sel,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   lock,
  output logic [NREG*DATA_W-1:0] regs_flat
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] wmask;

    assign wmask = lock ? EXEMPT[g*DATA_W +: DATA_W] : {DATA_W{1'b1}};

    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (wr_sel[g]) q <= (q & ~wmask) | (wdata & wmask);
    end

    assign regs_flat[g*DATA_W +: DATA_W] = q;
  end

endmodule

// File: rtl/clkgen_run_gate.sv
module clkgen_run_gate #(
  parameter int unsigned NREQ = 8
) (
  input  logic            en,
  input  logic            od,
  input  logic [NREQ-1:0] req,
  output logic            any_req,
  output logic            run
);

  assign any_req = |req;
  assign run     = en && (!od || any_req);

endmodule

// File: rtl/clkgen_ctrl_regs.sv
module clkgen_ctrl_regs
  import clkgen_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREQ   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NREQ-1:0]   periph_req,
  output logic              osc_run,
  output logic              cfg_err,
  output logic [2:0]        bw_sel,
  output logic [2:0]        ref_sel
);

  localparam int unsigned NDIV = 3;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  // last divider word (post-divider) keeps bit 0 open under lock
  localparam logic [NDIV*DATA_W-1:0] DIV_EXEMPT =
    {{(DATA_W-1){1'b0}}, 1'b1, {((NDIV-1)*DATA_W){1'b0}}};

  ctrl_t                   ctrl_q;
  ctrl_t                   ctrl_wr;
  logic                    hit_ctrl;
  logic [NDIV-1:0]         hit_div;
  logic [NDIV*DATA_W-1:0]  div_flat;
  logic                    frozen, locked, wr_taken, bw_drop, src_drop;
  logic                    any_req;
  logic [DATA_W-1:0]       fb_q, rdv_q, pd_q;

  assign hit_ctrl = bus_wr && (bus_addr == CTRL_A);
  assign ctrl_wr  = ctrl_unpack(bus_wdata[31:0]);

  for (genvar i = 0; i < NDIV; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] DA = ADDR_W'(CTRL_OFS + WORD_STEP*(i+1));
    assign hit_div[i] = bus_wr && (bus_addr == DA);
  end

  clkgen_ctrl_field u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit   (hit_ctrl),
    .wr_val   (ctrl_wr),
    .state    (ctrl_q),
    .frozen   (frozen),
    .locked   (locked),
    .wr_taken (wr_taken),
    .bw_drop  (bw_drop),
    .src_drop (src_drop),
    .cfg_err  (cfg_err)
  );

  clkgen_div_bank #(
    .NREG   (NDIV),
    .DATA_W (DATA_W),
    .EXEMPT (DIV_EXEMPT)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_sel    (hit_div),
    .wdata     (bus_wdata),
    .lock      (locked),
    .regs_flat (div_flat)
  );

  clkgen_run_gate #(.NREQ(NREQ)) u_run (
    .en      (ctrl_q.en),
    .od      (ctrl_q.od),
    .req     (periph_req),
    .any_req (any_req),
    .run     (osc_run)
  );

  assign fb_q  = div_flat[0*DATA_W +: DATA_W];
  assign rdv_q = div_flat[1*DATA_W +: DATA_W];
  assign pd_q  = div_flat[2*DATA_W +: DATA_W];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_A)                           bus_rdata = DATA_W'(ctrl_pack(ctrl_q));
    else if (bus_addr == ADDR_W'(CTRL_OFS + 1*WORD_STEP)) bus_rdata = fb_q;
    else if (bus_addr == ADDR_W'(CTRL_OFS + 2*WORD_STEP)) bus_rdata = rdv_q;
    else if (bus_addr == ADDR_W'(CTRL_OFS + 3*WORD_STEP)) bus_rdata = pd_q;
  end

  assign bw_sel  = ctrl_q.bw;
  assign ref_sel = ctrl_q.src;

endmodule

// File: rtl/clkgen_ctrl_chk.sv
module clkgen_ctrl_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREQ   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              en_q,
  input logic              lock_q,
  input logic              od_q,
  input logic [2:0]        bw_q,
  input logic [2:0]        src_q,
  input logic [DATA_W-1:0] fb_q,
  input logic [DATA_W-1:0] rdv_q,
  input logic [DATA_W-1:1] pd_hi,
  input logic [NREQ-1:0]   periph_req,
  input logic              osc_run,
  input logic              cfg_err
);

  // R3
  frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> ($stable(bw_q) && $stable(src_q) && $stable(od_q)));

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (lock_q && $stable(en_q)));

  // R6
  div_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(fb_q) && $stable(rdv_q) && $stable(pd_hi)));

  // R4
  bw_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bw_q <= 3'd4);

  // R5
  src_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_q <= 3'd2);

  // R4
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> ($past(bus_wr) && !$past(lock_q) && !$past(en_q)));

  // R8
  run_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_run |-> en_q);

  // R8
  run_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !od_q) |-> osc_run);

  // R9
  run_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (od_q && (periph_req == '0)) |-> !osc_run);

endmodule

bind clkgen_ctrl_regs clkgen_ctrl_chk #(.DATA_W(DATA_W), .NREQ(NREQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .en_q       (ctrl_q.en),
  .lock_q     (ctrl_q.lock),
  .od_q       (ctrl_q.od),
  .bw_q       (ctrl_q.bw),
  .src_q      (ctrl_q.src),
  .fb_q       (fb_q),
  .rdv_q      (rdv_q),
  .pd_hi      (pd_q[DATA_W-1:1]),
  .periph_req (periph_req),
  .osc_run    (osc_run),
  .cfg_err    (cfg_err)
);

// File: tb/tb_clkgen_ctrl_regs.sv
module tb_clkgen_ctrl_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  periph_req = '0;
  logic        osc_run, cfg_err;
  logic [2:0]  bw_sel, ref_sel;

  always #4 clk = ~clk;

  clkgen_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_req(periph_req),
    .osc_run(osc_run), .cfg_err(cfg_err), .bw_sel(bw_sel), .ref_sel(ref_sel)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // expected state, kept from the requirements
  logic [2:0]  m_bw, m_src;
  logic        m_od, m_lk, m_en;
  logic [31:0] m_fb, m_rdv, m_pd;
  logic        m_err;

  localparam logic [31:0] UNUSED_BITS = 32'hFFFF_C079;

  function automatic logic [31:0] mk(input logic [2:0] bw, input logic [2:0] s,
                                     input logic od, input logic lk, input logic en);
    return {18'b0, bw, s, od, 4'b0, lk, en, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    m_err = 1'b0;
    case (a)
      8'h40: if (!m_lk) begin
        if (!m_en) begin
          m_od = d[7];
          if (d[13:11] >= 3'd1 && d[13:11] <= 3'd4) m_bw = d[13:11]; else m_err = 1'b1;
          if (d[10:8] <= 3'd2) m_src = d[10:8]; else m_err = 1'b1;
        end
        m_en = d[1];
        m_lk = d[2];
      end
      8'h44: if (!m_lk) m_fb = d;
      8'h48: if (!m_lk) m_rdv = d;
      8'h4C: if (!m_lk) m_pd = d; else m_pd[0] = d[0];
      default: ;
    endcase
  endtask

  task automatic wr(input string req, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    model_write(a, d);
    @(negedge clk);
    bus_wr = 1'b0;
    chk({req, " err pulse"}, {31'b0, cfg_err}, {31'b0, m_err});
    @(negedge clk);
    chk({req, " err one cycle"}, {31'b0, cfg_err}, 32'b0);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic regs_chk(input string req);
    rd_chk({req, " ctrl"}, 8'h40, mk(m_bw, m_src, m_od, m_lk, m_en));
    rd_chk({req, " fbdiv"}, 8'h44, m_fb);
    rd_chk({req, " refdiv"}, 8'h48, m_rdv);
    rd_chk({req, " postdiv"}, 8'h4C, m_pd);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    m_bw = 0; m_src = 0; m_od = 0; m_lk = 0; m_en = 0;
    m_fb = 0; m_rdv = 0; m_pd = 0; m_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    regs_chk("R1");
    chk("R1 osc_run", {31'b0, osc_run}, 32'b0);
    chk("R1 cfg_err", {31'b0, cfg_err}, 32'b0);

    // R11 unmapped reads
    rd_chk("R11 read 0x00", 8'h00, 32'b0);
    rd_chk("R11 read 0x50", 8'h50, 32'b0);

    // R2 R4 R5 sweep of every bandwidth/reference pair with spare bits set
    for (int b = 0; b < 8; b++) begin
      for (int s = 0; s < 8; s++) begin
        wr("R4 R5 sweep", 8'h40,
           UNUSED_BITS | mk(3'(b), 3'(s), 1'((b + s) & 1), 1'b0, 1'b0));
        rd_chk("R2 R4 R5 ctrl", 8'h40, mk(m_bw, m_src, m_od, m_lk, m_en));
        chk("R2 bw_sel port", {29'b0, bw_sel}, {29'b0, m_bw});
        chk("R2 ref_sel port", {29'b0, ref_sel}, {29'b0, m_src});
      end
    end

    // R8 R9 run gating over every request pattern
    for (int od = 0; od < 2; od++) begin
      for (int en = 0; en < 2; en++) begin
        wr("R10 disable", 8'h40, mk(3'd2, 3'd1, 1'(od), 1'b0, 1'b0));
        wr("R10 set en", 8'h40, mk(3'd2, 3'd1, 1'(od), 1'b0, 1'(en)));
        for (int r = 0; r < 256; r++) begin
          @(negedge clk);
          periph_req = 8'(r);
          #1;
          chk(od ? "R9 run" : "R8 run", {31'b0, osc_run},
              {31'b0, (en != 0) && (od == 0 || r != 0)});
        end
      end
    end
    periph_req = '0;

    // R3 freeze while enabled (od=1, en=1 from the loop)
    regs_chk("R3 before");
    wr("R3 frozen write", 8'h40, mk(3'd4, 3'd2, 1'b0, 1'b0, 1'b1));
    regs_chk("R3 frozen");
    wr("R3 frozen reserved", 8'h40, mk(3'd7, 3'd6, 1'b0, 1'b0, 1'b1));
    regs_chk("R3 frozen reserved");

    // R10 disable then reconfigure
    wr("R10 disable", 8'h40, mk(3'd7, 3'd7, 1'b1, 1'b0, 1'b0));
    regs_chk("R10 disabled");
    wr("R10 reconfig", 8'h40, mk(3'd3, 3'd0, 1'b0, 1'b0, 1'b0));
    regs_chk("R10 reconfig");

    // R7 divider words unlocked
    wr("R7 fb", 8'h44, 32'hA5A5_1234);
    wr("R7 rdv", 8'h48, 32'h0F0F_00FF);
    wr("R7 pd", 8'h4C, 32'h8000_0002);
    regs_chk("R7 unlocked");

    // R11 unmapped write
    wr("R11 write 0x50", 8'h50, 32'hFFFF_FFFF);
    wr("R11 write 0x3C", 8'h3C, 32'hFFFF_FFFF);
    regs_chk("R11 after unmapped");

    // R6 lock and enable together
    wr("R6 lock", 8'h40, mk(3'd1, 3'd2, 1'b1, 1'b1, 1'b1));
    regs_chk("R6 locked");
    wr("R6 ctrl clear", 8'h40, 32'b0);
    wr("R6 ctrl reserved", 8'h40, mk(3'd0, 3'd7, 1'b0, 1'b0, 1'b0));
    wr("R6 fb", 8'h44, 32'h1111_1111);
    wr("R6 rdv", 8'h48, 32'h2222_2222);
    regs_chk("R6 after writes");
    wr("R7 pd bit0 set", 8'h4C, 32'hFFFF_FFFF);
    regs_chk("R7 pd set");
    chk("R7 pd value", m_pd, 32'h8000_0003);
    wr("R7 pd bit0 clear", 8'h4C, 32'h0000_0000);
    regs_chk("R7 pd clear");
    chk("R6 lock sticky", {31'b0, m_lk}, 32'd1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule